// File: doc/BRIEF.md
# Multicycle 8-bit Processor Core

This block is a small processor with an 8-bit datapath and 8-bit instructions. It has four 8-bit general registers, a zero flag and a negative flag. One external memory holds both the program and its data, and the core reaches it through a single port. That port carries an address, write data, read data, a read strobe and a write strobe. The memory is synchronous: read data for an address presented in one cycle is sampled by the core in the next cycle.

A control state machine steps each instruction through these phases in order:

1. fetch
2. instruction latch
3. operand read
4. execute
5. memory read (loads only)
6. register writeback

The fetch address and the load/store address share the one port through an address select. The program counter is advanced by the ALU using the constant 1. Branch targets are formed by the same ALU from the advanced PC and a sign-extended 4-bit offset.

Operand register fields sit in the top instruction bits and the opcode in the low bits. Programs place constants in registers with an OR-immediate that always targets register 1. They move data with register-indirect loads and stores, and steer control flow with three conditional relative branches.

Top module: `cpu8_core`

## Requirements
- R1: While reset is held and on release, the PC, all registers and both flags are 0. The first bus action after release is a read strobe at address 0, and no write strobe is raised during reset.
- R2: Each instruction is fetched from the address one above the previous instruction, unless a branch was taken. The PC value advances by exactly 1 in the cycle after each instruction byte is latched.
- R3: Low nibble 0100 is ADD, 0110 is SUB and 1000 is NAND. Each computes reg[ir[7:6]] op reg[ir[5:4]] modulo 256 and writes the result into reg[ir[7:6]].
- R4: ADD, SUB, NAND, OR-immediate and SHIFT set Z when their result is 0, and set N to result bit 7.
- R5: Low bits 111 mean OR-immediate. Register 1 becomes reg1 OR the zero-extended 5-bit value ir[7:3].
- R6: Low bits 011 mean SHIFT of reg[ir[7:6]] by ir[5:3] places. The shift is left when ir[6]=0 and logical right when ir[6]=1, and the result is written back to the same register.
- R7: Low nibble 0000 is LOAD. reg[ir[7:6]] receives the memory byte at the address held in reg[ir[5:4]], and the flags are unchanged.
- R8: Low nibble 0010 is STORE. The memory byte at the address in reg[ir[5:4]] receives reg[ir[7:6]], with exactly one write strobe cycle and no register change.
- R9: Low nibble 0001 is BZ (taken when Z=1), 1001 is BNZ (taken when Z=0) and 1101 is BPZ (taken when N=0). A taken branch loads PC+1+sign-extended ir[7:4]; a branch not taken continues at PC+1.
- R10: The undefined low nibbles 0101, 1010, 1100 and 1110 act as no-ops. They change no register and no flag, and only advance the PC.
- R11: The read strobe and the write strobe are never active in the same cycle.
- R12: ALU, OR-immediate and SHIFT instructions take 5 cycles, LOAD takes 6, and STORE, branches and no-ops take 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 8 | Memory address (PC at fetch, operand B at load/store) |
| mem_wdata | output | 8 | Store data (operand A) |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
Several properties are checked on every cycle:

- the exclusive use of the memory port by read and write;
- the one-step PC advance after each instruction latch;
- the fixed exit paths of the control state machine that set each instruction's cycle count;
- flags held steady across loads, stores, branches and no-ops;
- stores leaving the register file untouched.

The arithmetic results, the encodings, the branch conditions and the immediate handling are shown only by the bench's programs. Those programs sweep operand pairs, shift amounts and immediate values. They read results back through stores, and they infer flag state from which branch loop the core settles in.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int DW   = 8;
  localparam int NREG = 4;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_READ, ST_EXEC, ST_MEM, ST_WB
  } state_t;

  typedef enum logic [3:0] {
    IC_ADD, IC_SUB, IC_NAND, IC_SHL, IC_SHR, IC_ORI,
    IC_LOAD, IC_STORE, IC_BZ, IC_BNZ, IC_BPZ, IC_NOP
  } iclass_t;

  typedef enum logic [2:0] {
    AO_ADD, AO_SUB, AO_NAND, AO_OR, AO_SHL, AO_SHR
  } aluop_t;

  function automatic iclass_t decode(input logic [7:0] ir);
    iclass_t c;
    if (ir[2:0] == 3'b111)      c = IC_ORI;
    else if (ir[2:0] == 3'b011) c = ir[6] ? IC_SHR : IC_SHL;
    else begin
      case (ir[3:0])
        4'b0100: c = IC_ADD;
        4'b0110: c = IC_SUB;
        4'b1000: c = IC_NAND;
        4'b0000: c = IC_LOAD;
        4'b0010: c = IC_STORE;
        4'b0001: c = IC_BZ;
        4'b1001: c = IC_BNZ;
        4'b1101: c = IC_BPZ;
        default: c = IC_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic alu_class(input iclass_t c);
    return c inside {IC_ADD, IC_SUB, IC_NAND, IC_SHL, IC_SHR, IC_ORI};
  endfunction

  function automatic logic branch_class(input iclass_t c);
    return c inside {IC_BZ, IC_BNZ, IC_BPZ};
  endfunction

endpackage

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int W    = cpu8_pkg::DW,
  parameter int N    = cpu8_pkg::NREG,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (we && (wa == AW'(g)))             regs[g] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W   = DW,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_t       op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      AO_ADD:  y = a + b;
      AO_SUB:  y = a - b;
      AO_NAND: y = ~(a & b);
      AO_OR:   y = a | b;
      AO_SHL:  y = a << b[SW-1:0];
      AO_SHR:  y = a >> b[SW-1:0];
      default: y = a;
    endcase
  end

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ir,
  output state_t     state,
  output iclass_t    icls
);

  state_t state_nx;

  assign icls = decode(ir);

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH: state_nx = ST_LATCH;
      ST_LATCH: state_nx = ST_READ;
      ST_READ:  state_nx = ST_EXEC;
      ST_EXEC: begin
        if (icls == IC_LOAD)      state_nx = ST_MEM;
        else if (alu_class(icls)) state_nx = ST_WB;
        else                      state_nx = ST_FETCH;
      end
      ST_MEM:   state_nx = ST_WB;
      ST_WB:    state_nx = ST_FETCH;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nx;
  end

  // R12: four-cycle instructions return to fetch straight after execute
  assert_short_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !alu_class(icls) && icls != IC_LOAD) |=> state == ST_FETCH);

  // R12: a load spends exactly one cycle in the memory phase before writeback
  assert_load_path_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM) |=> state == ST_WB);

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       mem_rd,
  output logic       mem_wr
);

  localparam int AW = $clog2(NREG);

  logic          rst_meta, rst_sync_n;
  logic [DW-1:0] pc, ir, opa, opb, alu_q, mdr;
  logic          flag_z, flag_n;
  state_t        state;
  iclass_t       icls;
  logic [DW-1:0] alu_a, alu_b, alu_y, rf_a, rf_b, rf_wd;
  aluop_t        alu_op;
  logic [AW-1:0] ra_a, dst;
  logic          rf_we, taken, do_exec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cpu8_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ir    (ir),
    .state (state),
    .icls  (icls)
  );

  assign ra_a  = (icls == IC_ORI) ? AW'(1) : ir[7:6];
  assign dst   = ra_a;
  assign rf_we = (state == ST_WB);
  assign rf_wd = (icls == IC_LOAD) ? mdr : alu_q;

  cpu8_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ra_a  (ra_a),
    .ra_b  (ir[5:4]),
    .rd_a  (rf_a),
    .rd_b  (rf_b),
    .we    (rf_we),
    .wa    (dst),
    .wd    (rf_wd)
  );

  assign do_exec = (state == ST_EXEC);
  assign taken   = (icls == IC_BZ  &&  flag_z) ||
                   (icls == IC_BNZ && !flag_z) ||
                   (icls == IC_BPZ && !flag_n);

  // operand selection: PC for increment and branch target, else operand A
  always_comb begin
    alu_a  = opa;
    alu_b  = opb;
    alu_op = AO_ADD;
    if (state == ST_LATCH) begin
      alu_a = pc;
      alu_b = DW'(1);
    end else begin
      case (icls)
        IC_SUB:  alu_op = AO_SUB;
        IC_NAND: alu_op = AO_NAND;
        IC_ORI: begin
          alu_op = AO_OR;
          alu_b  = {{(DW-5){1'b0}}, ir[7:3]};
        end
        IC_SHL: begin
          alu_op = AO_SHL;
          alu_b  = {{(DW-3){1'b0}}, ir[5:3]};
        end
        IC_SHR: begin
          alu_op = AO_SHR;
          alu_b  = {{(DW-3){1'b0}}, ir[5:3]};
        end
        IC_BZ, IC_BNZ, IC_BPZ: begin
          alu_a = pc;
          alu_b = {{(DW-4){ir[7]}}, ir[7:4]};
        end
        default: alu_op = AO_ADD;
      endcase
    end
  end

  cpu8_alu #(.W(DW)) u_alu (
    .a  (alu_a),
    .b  (alu_b),
    .op (alu_op),
    .y  (alu_y)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc     <= '0;
      ir     <= '0;
      opa    <= '0;
      opb    <= '0;
      alu_q  <= '0;
      mdr    <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      if (state == ST_LATCH) begin
        ir <= mem_rdata;
        pc <= alu_y;
      end
      if (state == ST_READ) begin
        opa <= rf_a;
        opb <= rf_b;
      end
      if (do_exec && branch_class(icls) && taken) pc <= alu_y;
      if (do_exec && alu_class(icls)) begin
        alu_q  <= alu_y;
        flag_z <= (alu_y == '0);
        flag_n <= alu_y[DW-1];
      end
      if (state == ST_MEM) mdr <= mem_rdata;
    end
  end

  assign mem_rd    = (state == ST_FETCH) || (do_exec && icls == IC_LOAD);
  assign mem_wr    = do_exec && (icls == IC_STORE);
  assign mem_addr  = (state == ST_FETCH) ? pc : opb;
  assign mem_wdata = opa;

  assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({mem_rd, mem_wr}));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_LATCH) |=> pc == $past(pc) + 8'd1);

  // R7 and R10: loads, stores, branches and no-ops keep the flags
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (do_exec && !alu_class(icls)) |=> $stable({flag_z, flag_n}));

  assert_store_noreg_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (icls == IC_STORE) |-> !rf_we);

endmodule

// File: tb/cpu8_core_bench.sv
module cpu8_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, mem_rd_unused;
  logic       mem_rd, mem_wr;
  logic [7:0] mem [256];

  int checks = 0, fails = 0;
  int cyc = 0, total_cyc = 0, wr_cnt = 0, clash = 0;
  int last_wr_cyc = 0, prev_wr_cyc = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  cpu8_core u_cpu8_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  assign mem_rd_unused = 8'h00;

  // synchronous single-port memory model
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    total_cyc++;
    if (rst_n) begin
      cyc++;
      if (mem_rd) last_rd = mem_addr;
      if (mem_wr) begin
        wr_cnt++;
        prev_wr_cyc = last_wr_cyc;
        last_wr_cyc = cyc;
      end
      if (mem_rd && mem_wr) clash++;
    end
  end

  initial begin
    while (total_cyc < 190000) @(negedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 190000)", total_cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic start_run(input int ncyc);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cyc = 0; wr_cnt = 0; clash = 0; last_wr_cyc = 0; prev_wr_cyc = 0;
    last_rd = 8'h00;
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  // outcome classes: 0 zero, 1 negative, 2 positive
  function automatic int cls_of(input logic [7:0] v);
    if (v == 8'h00) return 0;
    if (v[7])       return 1;
    return 2;
  endfunction

  function automatic int loop_cls(input logic [7:0] a);
    if (a == 8'd11 || a == 8'd12) return 1;
    if (a == 8'd13 || a == 8'd14) return 0;
    if (a == 8'd15 || a == 8'd16) return 2;
    return 9;
  endfunction

  // loads a into r2 and b into r3, sets r1=28, runs op, stores dst to 28,
  // then settles in a loop chosen by the flags
  task automatic run_template(input logic [7:0] op, input logic [1:0] dst,
                              input logic [7:0] a, input logic [7:0] b,
                              input logic [7:0] exp_v, input int exp_c,
                              input string req);
    clear_mem();
    mem[0]  = 8'hF7; mem[1]  = 8'h90; mem[2]  = 8'h56; mem[3]  = 8'hFF;
    mem[4]  = 8'hD0; mem[5]  = 8'h56; mem[6]  = 8'hE7; mem[7]  = op;
    mem[8]  = {dst, 2'b01, 4'b0010};
    mem[9]  = 8'h31; mem[10] = 8'h4D;
    mem[11] = 8'hF1; mem[12] = 8'hE9; mem[13] = 8'hF1; mem[14] = 8'hE9;
    mem[15] = 8'hF1; mem[16] = 8'hE9;
    mem[30] = a; mem[31] = b;
    start_run(90);
    check(req, int'(mem[28]), int'(exp_v));
    check({req, " flags R4 R9"}, loop_cls(last_rd), exp_c);
    check("R8 single write", wr_cnt, 1);
    check("R11 strobe clash", clash, 0);
  endtask

  initial begin
    logic [7:0] vals [8];
    vals = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

    // R1: state during reset and on release
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    check("R1 no write in reset", int'(mem_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first read strobe", int'(mem_rd), 1);
    check("R1 first address", int'(mem_addr), 0);

    // R3, R4, R7, R8, R9: ALU sweep over operand pairs
    for (int op = 0; op < 3; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [7:0] a, b, r, code;
          a = vals[i]; b = vals[j];
          case (op)
            0: begin code = 8'hB4; r = a + b;    end
            1: begin code = 8'hB6; r = a - b;    end
            default: begin code = 8'hB8; r = ~(a & b); end
          endcase
          run_template(code, 2'd2, a, b, r, cls_of(r), "R3 ALU result");
        end
      end
    end

    // R6, R4: shifts; r2 goes left, r3 goes right
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] a, r;
        a = vals[i];
        r = a << s;
        run_template({2'b10, 3'(s), 3'b011}, 2'd2, a, 8'h00, r, cls_of(r), "R6 shift left");
        r = a >> s;
        run_template({2'b11, 3'(s), 3'b011}, 2'd3, 8'h00, a, r, cls_of(r), "R6 shift right");
      end
    end

    // R10, R7: undefined codes leave r2 (loaded value) and the ORI flags
    begin
      logic [3:0] und [4];
      und = '{4'b0101, 4'b1010, 4'b1100, 4'b1110};
      for (int k = 0; k < 4; k++) begin
        run_template({4'hB, und[k]}, 2'd2, 8'h83, 8'h11, 8'h83, 2, "R10 R7 no-op keeps loaded reg");
      end
    end

    // R5: OR-immediate into r1, stored to address 0 via r0
    for (int x = 0; x < 32; x++) begin
      logic [4:0] ys [8];
      ys = '{5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd16, 5'd31, 5'd21};
      for (int y = 0; y < 8; y++) begin
        clear_mem();
        mem[0] = {5'(x), 3'b111};
        mem[1] = {ys[y], 3'b111};
        mem[2] = 8'h42;
        mem[3] = 8'hF1;
        mem[4] = 8'hE9;
        start_run(40);
        check("R5 ORI result", int'(mem[0]), x | int'(ys[y]));
      end
    end

    // R12, R2, R9: timing between two stores across ADD, LOAD, NOP, taken BZ
    clear_mem();
    mem[0] = 8'h02; mem[1] = 8'hA4; mem[2] = 8'hC0; mem[3] = 8'h05;
    mem[4] = 8'h11; mem[5] = 8'h02; mem[6] = 8'h02; mem[7] = 8'hF1;
    mem[8] = 8'hE9;
    start_run(60);
    check("R12 cycles between stores", last_wr_cyc - prev_wr_cyc, 23);
    check("R9 R2 taken branch skips one store", wr_cnt, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule